// File: doc/BRIEF.md
# Mobile SDRAM Power-Up Sequencer

This block takes a low-power SDRAM from the moment power and clock are stable to the point where it can accept normal traffic. After reset it holds the clock-enable pin high and issues no-operation commands for a programmable settling time. It then issues a precharge to every bank and a programmable number of auto-refresh commands, each given its recovery gap. Next it loads the standard mode register and then the mobile extended mode register, and waits out the required gap after each load.

The burst length, burst ordering, read latency, single-write mode, self-refresh array span and output drive strength all come from input ports. They are read when the matching register load is issued. The block raises `ready` once the sequence is complete, and the main memory controller takes over the command bus from that point. If the requested read latency or burst length is reserved, the standard register is never loaded. The block parks with an error flag set instead.

All wait times and the refresh count are parameters in clock cycles. Command encodings on the active-low strobes are: no-op {sel,row,col,wr} = 0111, precharge = 0010, auto-refresh = 0001, register load = 0000.

Top module: `mem_powerup_seq`

## Requirements
- R1: From reset release (cycle 0), the block issues no-op commands with clock enable high for exactly WAIT_CYCLES cycles. The first non-no-op command appears in cycle WAIT_CYCLES.
- R2: In cycle P = WAIT_CYCLES the block issues a precharge with mem_addr bit 10 high, all other address bits zero and bank_sel = 00.
- R3: Exactly REFRESH_COUNT auto-refresh commands are issued. The first is in cycle P + PRECHG_CYCLES and each later one follows REFRESH_CYCLES after the previous. Every cycle between commands is a no-op.
- R4: In cycle M = P + PRECHG_CYCLES + REFRESH_COUNT*REFRESH_CYCLES the standard register load is issued with bank_sel = 00. Its address fields are: burst length in bits 2:0, interleave in bit 3, read latency in bits 6:4, zeros in bits 8:7, single-write in bit 9, and zeros in bits 11:10.
- R5: In cycle E = M + MODESET_CYCLES the extended register load is issued with bank_sel = 10. Its address fields are: array span in bits 2:0, drive strength in bits 6:5, and all other bits zero.
- R6: Only no-op commands appear in the MODESET_CYCLES-1 cycles that follow each register load.
- R7: `ready` is low before cycle E + MODESET_CYCLES. It is high from that cycle on and stays high, while the bus carries only no-ops.
- R8: A read latency of 0 or 4 to 7, a burst length code of 4, 5 or 6, or code 7 (full page) together with interleave counts as reserved. In that case cycle M carries a no-op instead of the load, `cfg_err` is high from cycle M+1 and stays high, no further command follows, and `ready` stays low.
- R9: Asserting reset at any point returns the bus to no-op at once and clears `ready` and `cfg_err`. The next release restarts the whole sequence from cycle 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_burst_len | input | 3 | Burst length code (0..3 = 1,2,4,8; 7 = full page) |
| cfg_interleave | input | 1 | Burst ordering: 1 interleaved, 0 sequential |
| cfg_cas_lat | input | 3 | Read latency in cycles, 1 to 3 |
| cfg_single_wr | input | 1 | Single-beat writes with burst reads |
| cfg_span | input | 3 | Self-refresh array span code |
| cfg_drive | input | 2 | Output drive strength code |
| clk_en | output | 1 | Memory clock enable |
| sel_n | output | 1 | Chip select strobe, active low |
| row_stb_n | output | 1 | Row strobe, active low |
| col_stb_n | output | 1 | Column strobe, active low |
| wr_en_n | output | 1 | Write strobe, active low |
| bank_sel | output | 2 | Bank / register select |
| mem_addr | output | 12 | Multiplexed address / register value |
| ready | output | 1 | Sequence complete |
| cfg_err | output | 1 | Reserved configuration detected |

## Verification
The configuration check and the standard register load fall in the same cycle, M. In that one cycle the block must either issue the load or replace it with a no-op and arm the error flag. The bench provokes this by sweeping every combination of read latency, burst length code and burst ordering through a full sequence. For each combination it predicts arithmetically whether cycle M carries the load or a no-op, and whether the following cycles show the extended load and `ready` or a parked bus with `cfg_err`. A second collision is a reset landing mid-sequence or in the error state. The bench judges it by the bus going to no-op and the flags clearing immediately.

// File: rtl/mem_powerup_seq.sv
module mem_powerup_seq #(
  parameter int WAIT_CYCLES    = 26700,
  parameter int PRECHG_CYCLES  = 3,
  parameter int REFRESH_CYCLES = 10,
  parameter int REFRESH_COUNT  = 2,
  parameter int MODESET_CYCLES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  cfg_burst_len,
  input  logic        cfg_interleave,
  input  logic [2:0]  cfg_cas_lat,
  input  logic        cfg_single_wr,
  input  logic [2:0]  cfg_span,
  input  logic [1:0]  cfg_drive,
  output logic        clk_en,
  output logic        sel_n,
  output logic        row_stb_n,
  output logic        col_stb_n,
  output logic        wr_en_n,
  output logic [1:0]  bank_sel,
  output logic [11:0] mem_addr,
  output logic        ready,
  output logic        cfg_err
);

  localparam int MAXA = (WAIT_CYCLES > PRECHG_CYCLES) ? WAIT_CYCLES : PRECHG_CYCLES;
  localparam int MAXB = (REFRESH_CYCLES > MODESET_CYCLES) ? REFRESH_CYCLES : MODESET_CYCLES;
  localparam int MAXL = (MAXA > MAXB) ? MAXA : MAXB;
  localparam int CW   = $clog2(MAXL) + 1;
  localparam int RW   = $clog2(REFRESH_COUNT) + 1;

  typedef enum logic [2:0] {S_WAIT, S_PRE, S_REF, S_MRS, S_EMRS, S_DONE, S_ERR} state_t;

  state_t        state;
  logic [CW-1:0] cnt;
  logic [CW-1:0] len;
  logic [RW-1:0] refs;
  logic          last, first, bad;
  logic [3:0]    cmd;

  assign first  = (cnt == '0);
  assign last   = (cnt == len - CW'(1));
  assign bad    = (cfg_cas_lat == 3'd0) || (cfg_cas_lat > 3'd3) ||
                  (cfg_burst_len inside {3'd4, 3'd5, 3'd6}) ||
                  (cfg_burst_len == 3'd7 && cfg_interleave);
  assign clk_en  = 1'b1;
  assign ready   = (state == S_DONE);
  assign cfg_err = (state == S_ERR);
  assign {sel_n, row_stb_n, col_stb_n, wr_en_n} = cmd;

  always_comb begin
    case (state)
      S_WAIT:         len = CW'(WAIT_CYCLES);
      S_PRE:          len = CW'(PRECHG_CYCLES);
      S_REF:          len = CW'(REFRESH_CYCLES);
      S_MRS, S_EMRS:  len = CW'(MODESET_CYCLES);
      default:        len = CW'(1);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_WAIT;
      cnt   <= '0;
      refs  <= '0;
    end else begin
      cnt <= last ? '0 : cnt + CW'(1);
      case (state)
        S_WAIT: if (last) state <= S_PRE;
        S_PRE:  if (last) state <= S_REF;
        S_REF:  if (last) begin
                  refs <= refs + RW'(1);
                  if (refs == RW'(REFRESH_COUNT - 1)) state <= S_MRS;
                end
        S_MRS:  if (first && bad) begin
                  state <= S_ERR;
                  cnt   <= '0;
                end else if (last) state <= S_EMRS;
        S_EMRS: if (last) state <= S_DONE;
        default: cnt <= '0;
      endcase
    end
  end

  always_comb begin
    cmd      = 4'b0111;
    bank_sel = 2'b00;
    mem_addr = '0;
    if (first) begin
      case (state)
        S_PRE: begin
          cmd          = 4'b0010;
          mem_addr[10] = 1'b1;
        end
        S_REF: cmd = 4'b0001;
        S_MRS: if (!bad) begin
          cmd      = 4'b0000;
          mem_addr = {2'b00, cfg_single_wr, 2'b00, cfg_cas_lat, cfg_interleave, cfg_burst_len};
        end
        S_EMRS: begin
          cmd      = 4'b0000;
          bank_sel = 2'b10;
          mem_addr = {5'b0, cfg_drive, 2'b00, cfg_span};
        end
        default: cmd = 4'b0111;
      endcase
    end
  end

  logic bus_nop, bus_pre, bus_ref, bus_load;
  assign bus_nop  = ({sel_n, row_stb_n, col_stb_n, wr_en_n} == 4'b0111);
  assign bus_pre  = ({sel_n, row_stb_n, col_stb_n, wr_en_n} == 4'b0010);
  assign bus_ref  = ({sel_n, row_stb_n, col_stb_n, wr_en_n} == 4'b0001);
  assign bus_load = ({sel_n, row_stb_n, col_stb_n, wr_en_n} == 4'b0000);

  a_r2_pre_all_banks: assert property (@(posedge clk) disable iff (!rst_n)
    bus_pre |-> (mem_addr == 12'h400 && bank_sel == 2'b00));
  a_r3_refresh_gap: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ref |=> bus_nop);
  a_r5_ext_fields: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_load && bank_sel == 2'b10) |-> (mem_addr[11:7] == 5'b0 && mem_addr[4:3] == 2'b0));
  a_r6_load_gap: assert property (@(posedge clk) disable iff (!rst_n)
    bus_load |=> bus_nop);
  a_r7_ready_holds: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> (ready && bus_nop));
  a_r8_err_parks: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> (cfg_err && !ready && bus_nop));
  a_r8_err_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_err && ready));

endmodule

// File: tb/mem_powerup_seq_test.sv
module mem_powerup_seq_test;
  localparam int W = 10, TP = 3, TR = 5, NR = 3, TM = 2;
  localparam int P = W, R0 = W + TP, M = R0 + NR * TR, E = M + TM, D = E + TM;

  logic clk = 0, rst_n = 0;
  logic [2:0] bl = 0, cl = 1, span = 0;
  logic bt = 0, sw = 0;
  logic [1:0] drv = 0;
  logic clk_en, sel_n, row_stb_n, col_stb_n, wr_en_n, ready, cfg_err;
  logic [1:0] bank_sel;
  logic [11:0] mem_addr;
  int errors = 0, checks = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  mem_powerup_seq #(.WAIT_CYCLES(W), .PRECHG_CYCLES(TP), .REFRESH_CYCLES(TR),
                    .REFRESH_COUNT(NR), .MODESET_CYCLES(TM)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_burst_len(bl), .cfg_interleave(bt),
    .cfg_cas_lat(cl), .cfg_single_wr(sw), .cfg_span(span), .cfg_drive(drv),
    .clk_en(clk_en), .sel_n(sel_n), .row_stb_n(row_stb_n), .col_stb_n(col_stb_n),
    .wr_en_n(wr_en_n), .bank_sel(bank_sel), .mem_addr(mem_addr),
    .ready(ready), .cfg_err(cfg_err));

  function automatic logic [20:0] pack(logic [3:0] c, logic [1:0] b, logic [11:0] a,
                                       logic r, logic e);
    return {1'b1, c, b, a, r, e};
  endfunction

  task automatic check(logic [20:0] exp, string tag);
    logic [20:0] act;
    act = {clk_en, sel_n, row_stb_n, col_stb_n, wr_en_n, bank_sel, mem_addr, ready, cfg_err};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic start_seq();
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic run_cfg(int cfg);
    bit bad;
    logic [20:0] exp;
    string tag;
    cl = cfg[2:0]; bl = cfg[5:3]; bt = cfg[6];
    sw = cfg[0] ^ cfg[3]; span = 3'(cfg % 3); drv = cfg[5:4];
    bad = (cl == 0) || (cl > 3) || (bl inside {4, 5, 6}) || (bl == 7 && bt);
    start_seq();
    for (int i = 0; i < D + 4; i++) begin
      #1;
      exp = pack(4'b0111, 2'b00, 12'h000, 1'b0, 1'b0);
      if (i < P) tag = "R1 wait";
      else if (i == P) begin tag = "R2 precharge"; exp = pack(4'b0010, 2'b00, 12'h400, 0, 0); end
      else if (i < M) begin
        tag = "R3 refresh";
        if (i >= R0 && (i - R0) % TR == 0) exp = pack(4'b0001, 2'b00, 12'h000, 0, 0);
      end else if (bad) begin
        tag = "R8 reserved";
        if (i > M) exp = pack(4'b0111, 2'b00, 12'h000, 0, 1);
      end else if (i == M) begin
        tag = "R4 mode load";
        exp = pack(4'b0000, 2'b00, {2'b00, sw, 2'b00, cl, bt, bl}, 0, 0);
      end else if (i == E) begin
        tag = "R5 ext load";
        exp = pack(4'b0000, 2'b10, {5'b0, drv, 2'b00, span}, 0, 0);
      end else if (i < D) tag = "R6 load gap";
      else begin tag = "R7 ready"; exp = pack(4'b0111, 2'b00, 12'h000, 1, 0); end
      check(exp, tag);
      @(negedge clk);
    end
  endtask

  initial begin
    #1;
    check(pack(4'b0111, 2'b00, 12'h000, 0, 0), "R9 reset state");
    for (int cfg = 0; cfg < 128; cfg++) run_cfg(cfg);
    // R9: reset in the middle of refreshes
    cl = 2; bl = 2; bt = 0;
    start_seq();
    repeat (R0 + 2) @(negedge clk);
    rst_n = 0; #1;
    check(pack(4'b0111, 2'b00, 12'h000, 0, 0), "R9 mid reset");
    // R9: reset out of the error state
    cl = 0;
    start_seq();
    repeat (M + 3) @(negedge clk);
    #1 check(pack(4'b0111, 2'b00, 12'h000, 0, 1), "R8 parked");
    rst_n = 0; #1;
    check(pack(4'b0111, 2'b00, 12'h000, 0, 0), "R9 error cleared");
    run_cfg(10);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule